// File: doc/BRIEF.md
# Protected Clock Control and Charger Configuration Registers

This block is the bank of special-purpose registers inside a serial timekeeping device. It holds three registers. A control register carries a sticky write-lock bit, an enable for the square-wave output and one interrupt enable for each of the two alarms. A status register is read-only and shows the two alarm match flags. A configuration register for the backup charger drives decoded selection outputs for the charger's analog switches.

A serial front end that is already decoded presents byte accesses on a simple bus. A pulse on `bus_en` performs one access. When bit 7 of `bus_addr` is set, the access is a write, and it completes on that clock edge. When bit 7 is clear, the address selects a register that `bus_rdata` shows combinationally. There is no back-pressure: every access completes in one cycle.

Writes are blocked in two cases: while the device runs from its backup battery, and while the write-lock bit is set. The one exception is a control write that clears the lock. The charger configuration only takes effect when its upper nibble holds a fixed key. A resistor or diode field outside the allowed combinations keeps the charger off.

Top module: `rtc_special_regs`

## Requirements
- R1: After reset, control reads 0x40 (lock bit 6 set, all other bits 0). Charger configuration reads 0x5C. All charger outputs, `sqw_en`, `alm0_ie` and `alm1_ie` are 0.
- R2: With the lock clear, a write to 0x8F stores data bits 6 (lock), 2 (square-wave enable), 1 (alarm 1 interrupt enable) and 0 (alarm 0 interrupt enable). A read at 0x0F returns those bits in the same positions, with bits 7, 5, 4 and 3 reading 0.
- R3: With the lock set, a write to 0x8F whose bit 6 is 0 clears only the lock and leaves bits 2..0 unchanged. A write whose bit 6 is 1 changes nothing.
- R4: With the lock set, writes to 0x91 are ignored.
- R5: While `on_battery` is 1, no write changes any register.
- R6: A read at 0x10 returns {6'b0, `alm1_flag`, `alm0_flag`}. A write to 0x90 has no effect.
- R7: Writing 0x91 with the lock clear stores the byte. Reading 0x11 returns it: key in bits 7:4, diode select in bits 3:2, resistor select in bits 1:0.
- R8: `chg_en` is 1 only when the key is 4'b1010, the resistor select is not 00, and the diode select is 01 or 10.
- R9: When enabled, `chg_res` is one-hot: resistor select 01 gives bit 0, 10 gives bit 1 and 11 gives bit 2. `chg_diode` is one-hot: diode select 01 gives bit 0 (one diode) and 10 gives bit 1 (two diodes). When disabled, both are 0.
- R10: Reads of unimplemented addresses, and of any address with bit 7 set, return 0. Writes to unimplemented addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_addr | input | 8 | Register address; bit 7 set means write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current read address |
| on_battery | input | 1 | Device powered from backup battery; blocks writes |
| alm0_flag | input | 1 | Alarm 0 match flag from alarm logic |
| alm1_flag | input | 1 | Alarm 1 match flag from alarm logic |
| wp_o | output | 1 | Current write-lock bit |
| sqw_en | output | 1 | Square-wave output enable |
| alm0_ie | output | 1 | Alarm 0 interrupt enable |
| alm1_ie | output | 1 | Alarm 1 interrupt enable |
| chg_en | output | 1 | Charger enabled |
| chg_res | output | 3 | One-hot resistor selection |
| chg_diode | output | 2 | One-hot diode count selection |

## Verification
The assertions assume that `bus_en`, `bus_addr`, `bus_wdata` and `on_battery` change only between clock edges. They also assume the alarm flags come from synchronous logic. The bench drives every input on the falling edge and holds it across the next rising edge. Each write is a single-cycle pulse followed by an idle cycle, so each register update can be attributed to exactly one access.

// File: rtl/rtc_regs_pkg.sv
package rtc_regs_pkg;
  localparam int DATA_W   = 8;
  localparam int IDX_W    = 7;
  localparam int KEY_W    = 4;
  localparam int DS_W     = 2;
  localparam int RS_W     = 2;
  localparam int N_RES    = 3;
  localparam int N_DIODE  = 2;

  localparam logic [IDX_W-1:0] CTRL_IDX = 7'h0F;
  localparam logic [IDX_W-1:0] STAT_IDX = 7'h10;
  localparam logic [IDX_W-1:0] CHG_IDX  = 7'h11;

  localparam logic [KEY_W-1:0] CHG_KEY  = 4'b1010;

  typedef struct packed {
    logic [KEY_W-1:0] key;
    logic [DS_W-1:0]  dsel;
    logic [RS_W-1:0]  rsel;
  } chg_cfg_t;

  typedef struct packed {
    logic       wp;
    logic       sqw;
    logic [1:0] aie;
  } ctrl_t;
endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
  import rtc_regs_pkg::*;
#(
  parameter logic WP_RESET = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic       wr_wp,
  input  logic       wr_sqw,
  input  logic [1:0] wr_aie,
  output ctrl_t      ctrl_q
);
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_stb) begin
      if (!ctrl_q.wp) begin
        ctrl_d.wp  = wr_wp;
        ctrl_d.sqw = wr_sqw;
        ctrl_d.aie = wr_aie;
      end else if (!wr_wp) begin
        // locked: only the unlock itself is honoured
        ctrl_d.wp = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.wp  <= WP_RESET;
      ctrl_q.sqw <= 1'b0;
      ctrl_q.aie <= '0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end
endmodule

// File: rtl/rtc_chg_cfg.sv
module rtc_chg_cfg
  import rtc_regs_pkg::*;
#(
  parameter logic [DATA_W-1:0] CFG_RESET = 8'h5C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output chg_cfg_t          cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= chg_cfg_t'(CFG_RESET);
    else if (wr_stb) cfg_q <= chg_cfg_t'(wr_data);
  end
endmodule

// File: rtl/rtc_chg_decode.sv
module rtc_chg_decode
  import rtc_regs_pkg::*;
(
  input  chg_cfg_t           cfg,
  output logic               en,
  output logic [N_RES-1:0]   res_oh,
  output logic [N_DIODE-1:0] diode_oh
);
  logic key_ok, rs_ok, ds_ok;

  assign key_ok = (cfg.key == CHG_KEY);
  assign rs_ok  = (cfg.rsel != '0);
  assign ds_ok  = (cfg.dsel != '0) && (cfg.dsel <= DS_W'(N_DIODE));
  assign en     = key_ok && rs_ok && ds_ok;

  for (genvar i = 0; i < N_RES; i++) begin : g_res
    assign res_oh[i] = en && (cfg.rsel == RS_W'(i + 1));
  end

  for (genvar j = 0; j < N_DIODE; j++) begin : g_diode
    assign diode_oh[j] = en && (cfg.dsel == DS_W'(j + 1));
  end
endmodule

// File: rtl/rtc_special_regs.sv
module rtc_special_regs
  import rtc_regs_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic              WP_RESET  = 1'b1,
  parameter logic [DATA_W-1:0] CFG_RESET = 8'h5C
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 on_battery,
  input  logic                 alm0_flag,
  input  logic                 alm1_flag,
  output logic                 wp_o,
  output logic                 sqw_en,
  output logic                 alm0_ie,
  output logic                 alm1_ie,
  output logic                 chg_en,
  output logic [N_RES-1:0]     chg_res,
  output logic [N_DIODE-1:0]   chg_diode
);
  localparam int WR_BIT = ADDR_W - 1;

  logic             is_wr;
  logic             wr_ok;
  logic [IDX_W-1:0] idx;
  logic             ctrl_wr, chg_wr;
  ctrl_t            ctrl_q;
  chg_cfg_t         cfg_q;

  assign is_wr   = bus_en && bus_addr[WR_BIT];
  assign idx     = bus_addr[IDX_W-1:0];
  assign wr_ok   = is_wr && !on_battery;
  assign ctrl_wr = wr_ok && (idx == CTRL_IDX);
  assign chg_wr  = wr_ok && (idx == CHG_IDX) && !ctrl_q.wp;

  rtc_ctrl_reg #(.WP_RESET(WP_RESET)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (ctrl_wr),
    .wr_wp  (bus_wdata[6]),
    .wr_sqw (bus_wdata[2]),
    .wr_aie (bus_wdata[1:0]),
    .ctrl_q (ctrl_q)
  );

  rtc_chg_cfg #(.CFG_RESET(CFG_RESET)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (chg_wr),
    .wr_data (bus_wdata),
    .cfg_q   (cfg_q)
  );

  rtc_chg_decode u_dec (
    .cfg      (cfg_q),
    .en       (chg_en),
    .res_oh   (chg_res),
    .diode_oh (chg_diode)
  );

  always_comb begin
    bus_rdata = '0;
    if (!bus_addr[WR_BIT]) begin
      unique case (idx)
        CTRL_IDX: bus_rdata = {1'b0, ctrl_q.wp, 3'b000, ctrl_q.sqw, ctrl_q.aie};
        STAT_IDX: bus_rdata = {6'b0, alm1_flag, alm0_flag};
        CHG_IDX:  bus_rdata = cfg_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign wp_o    = ctrl_q.wp;
  assign sqw_en  = ctrl_q.sqw;
  assign alm1_ie = ctrl_q.aie[1];
  assign alm0_ie = ctrl_q.aie[0];
endmodule

// File: rtl/rtc_special_regs_chk.sv
module rtc_special_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_en,
  input logic [7:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       on_battery,
  input logic       wp_o,
  input logic       sqw_en,
  input logic       alm0_ie,
  input logic       alm1_ie,
  input logic       chg_en,
  input logic [2:0] chg_res,
  input logic [1:0] chg_diode
);
  logic any_wr;
  assign any_wr = bus_en && bus_addr[7];

  // R3: locked control register keeps its lower bits
  p_locked_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_o && any_wr) |=> $stable({sqw_en, alm1_ie, alm0_ie}));

  // R3: lock can only rise through an accepted control write with bit 6 set
  p_lock_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wp_o) |-> $past(any_wr && !on_battery && bus_addr == 8'h8F && bus_wdata[6]));

  // R4: locked charger configuration does not move
  p_locked_chg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_o && any_wr) |=> $stable({chg_en, chg_res, chg_diode}));

  // R5: battery operation freezes everything
  p_battery_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (on_battery && any_wr) |=> $stable({wp_o, sqw_en, alm1_ie, alm0_ie, chg_en, chg_res, chg_diode}));

  // R9: one-hot selections follow the enable
  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    chg_en |-> ($countones(chg_res) == 1 && $countones(chg_diode) == 1));

  p_off_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_en |-> (chg_res == 3'b000 && chg_diode == 2'b00));

  // R10: without a write strobe nothing changes
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> $stable({wp_o, sqw_en, alm1_ie, alm0_ie, chg_en, chg_res, chg_diode}));
endmodule

bind rtc_special_regs rtc_special_regs_chk u_chk (.*);

// File: tb/rtc_special_regs_bench.sv
`timescale 1ns/1ps
module rtc_special_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_en = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       on_battery = 1'b0;
  logic       alm0_flag = 1'b0;
  logic       alm1_flag = 1'b0;
  logic       wp_o, sqw_en, alm0_ie, alm1_ie, chg_en;
  logic [2:0] chg_res;
  logic [1:0] chg_diode;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  rtc_special_regs u_rtc_special_regs (.*);

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [5:0] chg_model(input logic [7:0] v);
    logic       en;
    logic [2:0] r;
    logic [1:0] dd;
    en = (v[7:4] == 4'b1010) && (v[1:0] != 2'b00) && (v[3:2] == 2'b01 || v[3:2] == 2'b10);
    r  = 3'b000; dd = 2'b00;
    if (en) begin
      case (v[1:0]) 2'b01: r = 3'b001; 2'b10: r = 3'b010; default: r = 3'b100; endcase
      dd = (v[3:2] == 2'b01) ? 2'b01 : 2'b10;
    end
    return {en, r, dd};
  endfunction

  task automatic t_reset;
    logic [7:0] d;
    rd(8'h0F, d); check("R1 ctrl reset", d, 8'h40);
    rd(8'h11, d); check("R1 charger reset", d, 8'h5C);
    check("R1 outputs reset", {sqw_en, alm1_ie, alm0_ie, chg_en, chg_res, chg_diode}, 0);
  endtask

  task automatic t_locked;
    logic [7:0] d;
    wr(8'h91, 8'hA5);
    rd(8'h11, d); check("R4 locked charger", d, 8'h5C);
    wr(8'h8F, 8'h47);
    rd(8'h0F, d); check("R3 locked set ignored", d, 8'h40);
    wr(8'h8F, 8'h07);
    rd(8'h0F, d); check("R3 unlock only", d, 8'h00);
  endtask

  task automatic t_ctrl;
    logic [7:0] d;
    wr(8'h8F, 8'hFF);
    rd(8'h0F, d); check("R2 ctrl write", d, 8'h47);
    check("R2 ctrl pins", {wp_o, sqw_en, alm1_ie, alm0_ie}, 4'hF);
    wr(8'h8F, 8'h00);
    rd(8'h0F, d); check("R3 unlock keeps low bits", d, 8'h07);
    wr(8'h8F, 8'h02);
    rd(8'h0F, d); check("R2 ctrl partial", d, 8'h02);
    check("R2 ctrl pins partial", {wp_o, sqw_en, alm1_ie, alm0_ie}, 4'h2);
  endtask

  task automatic t_charger;
    logic [7:0] d;
    logic [7:0] vals [12] = '{8'hA5, 8'hA6, 8'hA7, 8'hA9, 8'hAA, 8'hAB,
                              8'hA4, 8'hA0, 8'hAD, 8'hB5, 8'h25, 8'h5C};
    foreach (vals[i]) begin
      wr(8'h91, vals[i]);
      rd(8'h11, d); check("R7 charger readback", d, vals[i]);
      check("R8 R9 charger decode", {chg_en, chg_res, chg_diode}, chg_model(vals[i]));
    end
  endtask

  task automatic t_status;
    logic [7:0] d;
    for (int k = 0; k < 4; k++) begin
      alm1_flag = k[1]; alm0_flag = k[0];
      rd(8'h10, d); check("R6 status read", d, {6'b0, k[1:0]});
    end
    wr(8'h90, 8'hFF);
    rd(8'h10, d); check("R6 status write ignored", d, 8'h03);
    rd(8'h0F, d); check("R6 ctrl untouched", d, 8'h02);
    alm1_flag = 1'b0; alm0_flag = 1'b0;
  endtask

  task automatic t_battery;
    logic [7:0] d;
    wr(8'h91, 8'hA5);
    on_battery = 1'b1;
    wr(8'h8F, 8'h45);
    wr(8'h91, 8'hAB);
    rd(8'h0F, d); check("R5 battery ctrl", d, 8'h02);
    rd(8'h11, d); check("R5 battery charger", d, 8'hA5);
    on_battery = 1'b0;
    wr(8'h91, 8'hAB);
    rd(8'h11, d); check("R5 write after battery", d, 8'hAB);
  endtask

  task automatic t_unimpl;
    logic [7:0] d;
    wr(8'h80, 8'hFF);
    wr(8'hFF, 8'hFF);
    rd(8'h0F, d); check("R10 ctrl after stray writes", d, 8'h02);
    rd(8'h11, d); check("R10 charger after stray writes", d, 8'hAB);
    rd(8'h00, d); check("R10 read 00", d, 8'h00);
    rd(8'h7F, d); check("R10 read 7F", d, 8'h00);
    rd(8'h8F, d); check("R10 read write-address", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_locked;
    t_ctrl;
    t_charger;
    t_status;
    t_battery;
    t_unimpl;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule